// File: doc/BRIEF.md
# Read-Ahead Prefetch Controller

This block sits between the target side of a PCI bridge and the path that reads local memory. For each data phase of a PCI read it decides whether the requested word is already held in a small staging buffer. If the word is there, the block returns it in the same cycle. If it is not, the block asks the memory side for more data.

When the read-ahead enable is set and the transaction uses one of the two block-read commands, a miss fetches a whole cache line. After that fill returns, the block keeps requesting the next sequential lines on its own, up to a fixed number of lines ahead of the one being read. A plain memory read, or any read while the enable is clear, fetches only the single requested word. Every held line and word is discarded when the PCI transaction ends. A fetch that is still in flight at that moment has its data dropped when it arrives.

At most one fetch is outstanding at a time, and the memory side answers each fetch with one fill beat that carries a full line. The PCI side keeps its data-phase strobe asserted and re-presents the address until the hit output rises.

Top module: `pf_readahead`

## Requirements
- R1: A data-phase miss with the enable set and a command of 4'hE (read line) or 4'hC (read multiple) issues a line fetch. The fetch has fetch_single low, and fetch_addr is the word address with its low log2(LINE_WORDS) bits cleared.
- R2: A data-phase miss with command 4'h6 (plain read), or with the enable clear, issues a fetch with fetch_single high for exactly the requested word address, and no speculative fetch follows it.
- R3: While the strobe is high and the addressed word is held, rd_hit is high in that same cycle and rd_data carries that word. A held line returns word (address mod LINE_WORDS) from lane (address mod LINE_WORDS) of its fill. A held single word returns lane 0 of its fill.
- R4: Once a line fill has returned in read-ahead mode, the block requests the next sequential line whenever no fetch is outstanding and a buffer slot is free. This continues until PF_AHEAD lines beyond the one being read are held.
- R5: At most one fetch is outstanding; a request is never raised in the cycle right after another request, nor before the previous fill has returned.
- R6: A miss on a word that is not held, with no fetch outstanding, discards all held data and fetches the word's line, or the single word in R2 mode. Prefetching then continues from the line after the new one.
- R7: In a cycle with the end-of-transaction input high, no fetch is requested. From the following cycle on, no data held before the end can produce a hit.
- R8: A fill that returns for a fetch issued before an end of transaction is discarded. A later access to that data misses and fetches it again.
- R9: Reading the last word of a held line, or reading a held single word, frees its slot, so a further prefetch can be requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_enable | input | 1 | Read-ahead enable |
| pci_cmd | input | 4 | PCI command code of the current transaction |
| pci_addr | input | ADDR_W | Word address of the current data phase |
| dphase | input | 1 | Data-phase strobe; held until rd_hit |
| xact_end | input | 1 | One-cycle end of the PCI transaction |
| fetch_req | output | 1 | One-cycle fetch request to local memory |
| fetch_addr | output | ADDR_W | Word address of the fetch (line base for line fetches) |
| fetch_single | output | 1 | High: fetch one word; low: fetch a full line |
| fill_valid | input | 1 | Fill beat for the outstanding fetch |
| fill_data | input | LINE_WORDS*DATA_W | Fill data, word i in lane i (single word in lane 0) |
| rd_hit | output | 1 | Requested word is served this cycle |
| rd_data | output | DATA_W | Served word (zero when rd_hit is low) |

## Verification
Several rules are checked on every cycle: line fetches are aligned, a cleared enable yields only single-word fetches, a hit only occurs under the strobe, requests are never back to back, and the end cycle is quiet and is followed by no hit. The sequence of fetch addresses cannot be shown by a per-cycle property. That covers how many lines run ahead, the restart after a non-sequential jump, slot release after the last word of a line, and the dropping of a fill that raced an end of transaction. Those are shown by scenarios whose fetch log and per-cycle outputs are compared with a behavioural model.

// File: rtl/pf_pkg.sv
package pf_pkg;

    localparam logic [3:0] CMD_MEM_READ  = 4'h6;
    localparam logic [3:0] CMD_READ_LINE = 4'hE;
    localparam logic [3:0] CMD_READ_MULT = 4'hC;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_PEND  = 2'd1,
        SLOT_FULL  = 2'd2
    } slot_state_e;

    // true when this data phase is allowed to fetch speculatively
    function automatic logic wants_prefetch(input logic enable, input logic [3:0] cmd);
        return enable && (cmd == CMD_READ_LINE || cmd == CMD_READ_MULT);
    endfunction

endpackage

// File: rtl/pf_slot_array.sv
module pf_slot_array
    import pf_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SLOTS      = 3,
    parameter int OFF_W      = 2,
    parameter int IDX_W      = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         look_valid,
    input  logic [ADDR_W-1:0]            look_addr,
    input  logic                         flush,
    input  logic                         alloc,
    input  logic [IDX_W-1:0]             alloc_idx,
    input  logic [ADDR_W-1:0]            alloc_tag,
    input  logic                         alloc_single,
    input  logic                         fill_we,
    input  logic [IDX_W-1:0]             fill_idx,
    input  logic [LINE_WORDS*DATA_W-1:0] fill_data,
    output logic                         hit,
    output logic [DATA_W-1:0]            hit_data,
    output logic                         free_any,
    output logic [IDX_W-1:0]             free_idx
);

    localparam int LINE_BITS = LINE_WORDS * DATA_W;

    typedef struct packed {
        slot_state_e         st;
        logic                single;
        logic [ADDR_W-1:0]   tag;
    } slot_meta_t;

    logic [SLOTS-1:0]     match_v;
    logic [SLOTS-1:0]     empty_v;
    logic [SLOTS-1:0]     single_v;
    logic [LINE_BITS-1:0] line_v [SLOTS];
    logic [IDX_W-1:0]     hit_idx;
    logic                 last_word;

    assign last_word = (look_addr[OFF_W-1:0] == {OFF_W{1'b1}});

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        slot_meta_t            meta_q;
        logic [LINE_BITS-1:0]  data_q;
        logic                  consume;

        assign consume = look_valid && match_v[g] && (hit_idx == IDX_W'(g))
                         && (meta_q.single || last_word);

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= '{st: SLOT_EMPTY, single: 1'b0, tag: '0};
                data_q <= '0;
            end else begin
                if (flush || consume) begin
                    meta_q.st <= SLOT_EMPTY;
                end
                if (fill_we && fill_idx == IDX_W'(g)) begin
                    meta_q.st <= SLOT_FULL;
                    data_q    <= fill_data;
                end
                if (alloc && alloc_idx == IDX_W'(g)) begin
                    meta_q.st     <= SLOT_PEND;
                    meta_q.single <= alloc_single;
                    meta_q.tag    <= alloc_tag;
                end
            end
        end

        assign match_v[g]  = (meta_q.st == SLOT_FULL) &&
                             (meta_q.single ? (meta_q.tag == look_addr)
                                            : (meta_q.tag[ADDR_W-1:OFF_W] == look_addr[ADDR_W-1:OFF_W]));
        assign empty_v[g]  = (meta_q.st == SLOT_EMPTY);
        assign single_v[g] = meta_q.single;
        assign line_v[g]   = data_q;
    end

    // lowest matching slot and lowest empty slot
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match_v[i]) hit_idx = IDX_W'(i);
            if (empty_v[i]) free_idx = IDX_W'(i);
        end
    end

    assign hit      = look_valid && (|match_v);
    assign free_any = |empty_v;

    always_comb begin
        logic [OFF_W-1:0] lane;
        lane     = single_v[hit_idx] ? '0 : look_addr[OFF_W-1:0];
        hit_data = hit ? line_v[hit_idx][lane*DATA_W +: DATA_W] : '0;
    end

endmodule

// File: rtl/pf_issue_ctrl.sv
module pf_issue_ctrl
    import pf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ra_enable,
    input  logic [3:0]        pci_cmd,
    input  logic [ADDR_W-1:0] pci_addr,
    input  logic              dphase,
    input  logic              xact_end,
    input  logic              hit,
    input  logic              free_any,
    input  logic [IDX_W-1:0]  free_idx,
    input  logic              fill_valid,
    output logic              flush,
    output logic              alloc,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic [ADDR_W-1:0] alloc_tag,
    output logic              alloc_single,
    output logic              fill_we,
    output logic [IDX_W-1:0]  fill_idx
);

    localparam int LINE_AW = ADDR_W - OFF_W;

    logic               inflight_q;
    logic               drop_q;
    logic               spec_q;
    logic [LINE_AW-1:0] next_line_q;
    logic [IDX_W-1:0]   pend_idx_q;

    logic spec_now;
    logic demand;
    logic prefetch;

    assign spec_now = wants_prefetch(ra_enable, pci_cmd);
    assign demand   = dphase && !hit && !inflight_q && !xact_end;
    assign prefetch = !demand && spec_q && ra_enable && !inflight_q && !xact_end && free_any;

    assign flush        = xact_end || demand;
    assign alloc        = demand || prefetch;
    assign alloc_idx    = demand ? '0 : free_idx;
    assign alloc_single = demand && !spec_now;

    always_comb begin
        if (!demand)
            alloc_tag = {next_line_q, {OFF_W{1'b0}}};
        else if (spec_now)
            alloc_tag = {pci_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        else
            alloc_tag = pci_addr;
    end

    assign fill_we  = fill_valid && inflight_q && !drop_q && !xact_end;
    assign fill_idx = pend_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight_q  <= 1'b0;
            drop_q      <= 1'b0;
            spec_q      <= 1'b0;
            next_line_q <= '0;
            pend_idx_q  <= '0;
        end else begin
            if (fill_valid) begin
                inflight_q <= 1'b0;
                drop_q     <= 1'b0;
            end
            if (alloc) begin
                inflight_q <= 1'b1;
                pend_idx_q <= alloc_idx;
            end
            if (demand) begin
                spec_q <= spec_now;
                if (spec_now)
                    next_line_q <= pci_addr[ADDR_W-1:OFF_W] + 1'b1;
            end
            if (prefetch)
                next_line_q <= next_line_q + 1'b1;
            if (xact_end) begin
                spec_q <= 1'b0;
                if (inflight_q && !fill_valid)
                    drop_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pf_readahead.sv
module pf_readahead
    import pf_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int PF_AHEAD   = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ra_enable,
    input  logic [3:0]                   pci_cmd,
    input  logic [ADDR_W-1:0]            pci_addr,
    input  logic                         dphase,
    input  logic                         xact_end,
    output logic                         fetch_req,
    output logic [ADDR_W-1:0]            fetch_addr,
    output logic                         fetch_single,
    input  logic                         fill_valid,
    input  logic [LINE_WORDS*DATA_W-1:0] fill_data,
    output logic                         rd_hit,
    output logic [DATA_W-1:0]            rd_data
);

    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int SLOTS = PF_AHEAD + 1;
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic              flush;
    logic              alloc;
    logic [IDX_W-1:0]  alloc_idx;
    logic [ADDR_W-1:0] alloc_tag;
    logic              alloc_single;
    logic              fill_we;
    logic [IDX_W-1:0]  fill_idx;
    logic              free_any;
    logic [IDX_W-1:0]  free_idx;

    pf_issue_ctrl #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ra_enable    (ra_enable),
        .pci_cmd      (pci_cmd),
        .pci_addr     (pci_addr),
        .dphase       (dphase),
        .xact_end     (xact_end),
        .hit          (rd_hit),
        .free_any     (free_any),
        .free_idx     (free_idx),
        .fill_valid   (fill_valid),
        .flush        (flush),
        .alloc        (alloc),
        .alloc_idx    (alloc_idx),
        .alloc_tag    (alloc_tag),
        .alloc_single (alloc_single),
        .fill_we      (fill_we),
        .fill_idx     (fill_idx)
    );

    pf_slot_array #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS),
        .SLOTS      (SLOTS),
        .OFF_W      (OFF_W),
        .IDX_W      (IDX_W)
    ) u_slots (
        .clk          (clk),
        .rst          (rst),
        .look_valid   (dphase),
        .look_addr    (pci_addr),
        .flush        (flush),
        .alloc        (alloc),
        .alloc_idx    (alloc_idx),
        .alloc_tag    (alloc_tag),
        .alloc_single (alloc_single),
        .fill_we      (fill_we),
        .fill_idx     (fill_idx),
        .fill_data    (fill_data),
        .hit          (rd_hit),
        .hit_data     (rd_data),
        .free_any     (free_any),
        .free_idx     (free_idx)
    );

    assign fetch_req    = alloc;
    assign fetch_addr   = alloc_tag;
    assign fetch_single = alloc_single;

endmodule

// File: rtl/pf_readahead_chk.sv
module pf_readahead_chk #(
    parameter int OFF_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ra_enable,
    input logic             dphase,
    input logic             xact_end,
    input logic             fetch_req,
    input logic             fetch_single,
    input logic [OFF_W-1:0] fetch_off,
    input logic             rd_hit
);

    // R1: line fetches start at a line boundary
    p_line_aligned_r1: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_single) |-> (fetch_off == '0));

    // R2: with the enable clear nothing speculative is fetched
    p_single_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !ra_enable) |-> fetch_single);

    // R3: data is only served during a data phase
    p_hit_in_phase_r3: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> dphase);

    // R5: one fetch in flight, so requests are never back to back
    p_no_back_to_back_r5: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> !fetch_req);

    // R7: the end cycle issues nothing
    p_quiet_end_r7: assert property (@(posedge clk) disable iff (rst)
        xact_end |-> !fetch_req);

    // R7: nothing held survives the end
    p_no_hit_after_end_r7: assert property (@(posedge clk) disable iff (rst)
        xact_end |=> !rd_hit);

endmodule

bind pf_readahead pf_readahead_chk #(
    .OFF_W (OFF_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ra_enable    (ra_enable),
    .dphase       (dphase),
    .xact_end     (xact_end),
    .fetch_req    (fetch_req),
    .fetch_single (fetch_single),
    .fetch_off    (fetch_addr[OFF_W-1:0]),
    .rd_hit       (rd_hit)
);

// File: tb/test_pf_readahead.sv
`timescale 1ns/1ps
module test_pf_readahead;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int PF_AHEAD   = 2;
    localparam int SLOTS      = PF_AHEAD + 1;
    localparam int LAT        = 2;
    localparam logic [3:0] C_RD  = 4'h6;
    localparam logic [3:0] C_RL  = 4'hE;
    localparam logic [3:0] C_RM  = 4'hC;

    logic                         clk = 1'b0;
    logic                         rst;
    logic                         ra_enable;
    logic [3:0]                   pci_cmd;
    logic [ADDR_W-1:0]            pci_addr;
    logic                         dphase;
    logic                         xact_end;
    logic                         fetch_req;
    logic [ADDR_W-1:0]            fetch_addr;
    logic                         fetch_single;
    logic                         fill_valid;
    logic [LINE_WORDS*DATA_W-1:0] fill_data;
    logic                         rd_hit;
    logic [DATA_W-1:0]            rd_data;

    always #2 clk = ~clk;

    pf_readahead #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LINE_WORDS (LINE_WORDS), .PF_AHEAD (PF_AHEAD)
    ) i_pf_readahead (
        .clk (clk), .rst (rst), .ra_enable (ra_enable), .pci_cmd (pci_cmd),
        .pci_addr (pci_addr), .dphase (dphase), .xact_end (xact_end),
        .fetch_req (fetch_req), .fetch_addr (fetch_addr), .fetch_single (fetch_single),
        .fill_valid (fill_valid), .fill_data (fill_data),
        .rd_hit (rd_hit), .rd_data (rd_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    function automatic logic [DATA_W-1:0] mem_word(input logic [15:0] a);
        return {a ^ 16'hA5A5, a};
    endfunction

    function automatic int base_of(input int a);
        return a & ~(LINE_WORDS - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // ---------------- fetch log and memory responder ----------------
    typedef struct { int addr; bit single; } req_t;
    req_t req_log[$];
    int   out_cnt = 0;
    int   max_out = 0;
    bit   f_pend  = 0;
    int   f_cnt   = 0;
    int   f_addr  = 0;
    bit   f_single = 0;

    always @(negedge clk) begin
        if (rst) begin
            f_pend = 0; out_cnt = 0;
        end else begin
            if (fill_valid) out_cnt--;
            if (fetch_req) begin
                req_t r;
                r.addr = int'(fetch_addr); r.single = fetch_single;
                req_log.push_back(r);
                out_cnt++;
                f_pend = 1; f_cnt = LAT; f_addr = int'(fetch_addr); f_single = fetch_single;
            end
            if (out_cnt > max_out) max_out = out_cnt;
        end
    end

    initial begin
        fill_valid = 0; fill_data = '0;
        forever begin
            @(posedge clk); #1;
            fill_valid = 0;
            if (f_pend) begin
                if (f_cnt == 0) begin
                    fill_valid = 1;
                    fill_data  = '0;
                    if (f_single)
                        fill_data[DATA_W-1:0] = mem_word(16'(f_addr));
                    else
                        for (int w = 0; w < LINE_WORDS; w++)
                            fill_data[w*DATA_W +: DATA_W] = mem_word(16'(f_addr + w));
                    f_pend = 0;
                end else begin
                    f_cnt--;
                end
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    typedef struct { int tag; bit single; } ent_t;
    ent_t rdy[$];
    bit   m_infl, m_drop, m_spec;
    ent_t m_inf;
    int   m_next;
    bit   d_hit, d_demand, d_pf, d_spec;
    int   d_pos;

    always @(negedge clk) begin
        if (!rst) begin
            int   hp;
            bit   e_req, e_single;
            int   e_addr;
            string tag;
            hp = -1;
            if (dphase)
                foreach (rdy[i])
                    if (hp < 0 && (rdy[i].single ? rdy[i].tag == int'(pci_addr)
                                                 : rdy[i].tag == base_of(int'(pci_addr))))
                        hp = i;
            d_hit    = dphase && hp >= 0;
            d_pos    = hp;
            d_spec   = ra_enable && (pci_cmd == C_RL || pci_cmd == C_RM);
            d_demand = dphase && !d_hit && !m_infl && !xact_end;
            d_pf     = !d_demand && m_spec && ra_enable && !m_infl && !xact_end && rdy.size() < SLOTS;
            e_req    = d_demand || d_pf;
            e_single = d_demand && !d_spec;
            e_addr   = d_demand ? (d_spec ? base_of(int'(pci_addr)) : int'(pci_addr)) : m_next;
            tag      = d_demand ? (d_spec ? "R1" : "R2") : (d_pf ? "R4" : "R5");
            chk(fetch_req == e_req, tag, "fetch_req", fetch_req, e_req);
            if (e_req && fetch_req) begin
                chk(int'(fetch_addr) == e_addr, tag, "fetch_addr", fetch_addr, e_addr);
                chk(fetch_single == e_single, tag, "fetch_single", fetch_single, e_single);
            end
            chk(rd_hit == d_hit, "R3", "rd_hit", rd_hit, d_hit);
            if (d_hit && rd_hit)
                chk(rd_data == mem_word(pci_addr), "R3", "rd_data", rd_data, mem_word(pci_addr));
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            rdy.delete(); m_infl = 0; m_drop = 0; m_spec = 0; m_next = 0;
            d_hit = 0; d_demand = 0; d_pf = 0;
        end else begin
            if (fill_valid) begin
                if (!m_drop && !xact_end) rdy.push_back(m_inf);
                m_infl = 0; m_drop = 0;
            end
            if (d_hit && (rdy[d_pos].single || (int'(pci_addr) % LINE_WORDS) == LINE_WORDS - 1))
                rdy.delete(d_pos);
            if (d_demand) begin
                rdy.delete();
                m_infl = 1;
                m_inf.single = !d_spec;
                m_inf.tag = d_spec ? base_of(int'(pci_addr)) : int'(pci_addr);
                m_spec = d_spec;
                if (d_spec) m_next = base_of(int'(pci_addr)) + LINE_WORDS;
            end
            if (d_pf) begin
                m_infl = 1; m_inf.single = 0; m_inf.tag = m_next;
                m_next += LINE_WORDS;
            end
            if (xact_end) begin
                rdy.delete(); m_spec = 0;
                if (m_infl) m_drop = 1;
            end
            d_hit = 0; d_demand = 0; d_pf = 0;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic read_word(input int a, input logic [3:0] c);
        @(posedge clk); #1;
        dphase = 1; pci_addr = 16'(a); pci_cmd = c;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (rd_hit) break;
        end
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1; dphase = 0;
        repeat (n - 1) @(posedge clk);
    endtask

    task automatic end_xact();
        @(posedge clk); #1; dphase = 0; xact_end = 1;
        @(posedge clk); #1; xact_end = 0;
    endtask

    function automatic int count_addr(input int a, input int from);
        int n = 0;
        for (int i = from; i < req_log.size(); i++) if (req_log[i].addr == a) n++;
        return n;
    endfunction

    // ---------------- scenarios ----------------
    initial begin
        int mark;
        rst = 1; ra_enable = 0; pci_cmd = C_RD; pci_addr = '0; dphase = 0; xact_end = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(!fetch_req && !rd_hit && rd_data == '0, "R5", "reset outputs", {fetch_req, rd_hit}, 0);

        // A: sequential block read with read-ahead
        ra_enable = 1;
        req_log.delete();
        read_word(16'h40, C_RL);
        idle(12);
        chk(req_log.size() == 3, "R4", "lines ahead after first fill", req_log.size(), 3);
        chk(req_log[0].addr == 'h40 && !req_log[0].single, "R1", "first line fetch", req_log[0].addr, 'h40);
        chk(req_log.size() > 2 && req_log[2].addr == 'h48, "R4", "second prefetch", req_log[2].addr, 'h48);
        for (int a = 'h41; a <= 'h43; a++) read_word(a, C_RL);
        idle(10);
        chk(req_log.size() == 4, "R9", "prefetch after line consumed", req_log.size(), 4);
        chk(req_log[3].addr == 'h4C, "R9", "refill address", req_log[3].addr, 'h4C);
        for (int a = 'h44; a <= 'h4B; a++) read_word(a, C_RL);
        idle(12);
        chk(count_addr('h44, 0) == 1, "R3", "no refetch of held line", count_addr('h44, 0), 1);
        @(posedge clk); #1 xact_end = 1;
        @(posedge clk); #1 xact_end = 0; dphase = 1; pci_addr = 16'h4C; pci_cmd = C_RL;
        @(negedge clk);
        chk(!rd_hit, "R7", "held line after end", rd_hit, 0);
        read_word(16'h4C, C_RL);
        idle(10);
        end_xact();

        // B: plain reads and disabled read-ahead
        req_log.delete();
        for (int a = 'h80; a <= 'h82; a++) read_word(a, C_RD);
        idle(8);
        chk(req_log.size() == 3, "R2", "plain read fetch count", req_log.size(), 3);
        foreach (req_log[i]) chk(req_log[i].single && req_log[i].addr == 'h80 + i, "R2", "plain read word fetch", req_log[i].addr, 'h80 + i);
        end_xact();
        ra_enable = 0;
        req_log.delete();
        read_word(16'h91, C_RM);
        read_word(16'h92, C_RM);
        idle(8);
        chk(req_log.size() == 2 && req_log[0].single && req_log[1].single, "R2", "disabled read-ahead fetches", req_log.size(), 2);
        end_xact();

        // C: non-sequential jump restarts prefetch
        ra_enable = 1;
        req_log.delete();
        read_word(16'h100, C_RM);
        idle(12);
        mark = req_log.size();
        read_word(16'h302, C_RM);
        idle(14);
        chk(count_addr('h300, mark) == 1, "R6", "jump line fetch", count_addr('h300, mark), 1);
        chk(req_log[req_log.size()-1].addr == 'h308, "R6", "prefetch after jump", req_log[req_log.size()-1].addr, 'h308);
        read_word(16'h104, C_RM);
        idle(6);
        chk(count_addr('h104, 0) == 2, "R6", "discarded line refetched", count_addr('h104, 0), 2);
        end_xact();

        // D: end while a prefetch is in flight
        req_log.delete();
        read_word(16'h200, C_RL);
        end_xact();
        read_word(16'h204, C_RL);
        chk(rd_hit == 1'b1, "R8", "read after dropped fill served", rd_hit, 1);
        chk(count_addr('h204, 0) == 2, "R8", "dropped line fetched again", count_addr('h204, 0), 2);
        idle(10);
        end_xact();

        chk(max_out <= 1, "R5", "outstanding fetches", max_out, 1);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule